// File: doc/BRIEF.md
# Comma-Triggered Latency Stopwatch

This block times how long a receive path takes to deliver its first comma after a measurement is launched. A single-cycle start pulse arms the stopwatch and zeroes it. From then on a measurement counter advances once every N system-clock cycles, where N is a programmable divide ratio. The first comma that is reported on the monitored receive lane freezes the count. Software then reads the frozen value through a read port. A read clears the counter.

Configuration is written through a register-style port. It holds a 7-bit divide ratio, a 2-bit lane selector and an enable bit. The divide ratio has a floor of 6. It can only be changed while the stopwatch is disabled. Only lane code 00 arms comma monitoring, and the other three codes are reserved and never stop a measurement. The counter saturates instead of wrapping. A read returns zero until a comma has been captured for the current measurement.

Top module: `latency_stopwatch`

## Requirements
- R1: After reset the read data is 0, the divide ratio is 6, the lane code is 00 and the stopwatch is disabled, so a read returns 0.
- R2: With the stopwatch enabled, a start sampled at edge E0 followed by a comma on lane 0 sampled at edge E0+M yields a count of floor((M-1)/N), where N is the divide ratio. The count is returned in rd_data one cycle after the rd_en edge.
- R3: A read clears the counter, so a second read with no new measurement returns 0. rd_data changes only in the cycle after an rd_en edge.
- R4: A read taken while a measurement is armed and no comma has yet arrived returns 0.
- R5: The count holds at all ones of its width (16'hFFFF by default) and never wraps.
- R6: A written divide ratio below 6 is stored as 6.
- R7: A divide-ratio write is ignored while the enable bit is currently set. The lane code and enable are still written.
- R8: Only lane code 00 monitors commas, using comma bit 0. With codes 01, 10 or 11 every comma is ignored and the measurement stays unfinished.
- R9: While disabled, start pulses and ticks have no effect, so a captured value survives a start issued while disabled.
- R10: Once a comma has frozen the count, further commas are ignored until the next start.
- R11: A read during an armed measurement zeroes the counter on the following cycle. Counting continues from there, so the final value counts only ticks strictly after the read edge and strictly before the comma edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 7 | Divide ratio to write |
| cfg_lane | input | 2 | Lane code to write (00 = monitor lane 0) |
| cfg_en | input | 1 | Enable bit to write |
| start | input | 1 | Measurement start pulse |
| comma | input | LANES (4) | Per-lane comma-detected pulses |
| rd_en | input | 1 | Read strobe; captures and clears the counter |
| rd_data | output | CNT_W (16) | Value captured by the last read |

## Verification
Several corner cases are targeted. A read while a measurement is still running must return zero and restart the count. A design that ignored the read or kept counting from the old value would report too large a result. A divide ratio written while enabled, or written below the floor, must leave the tick rate unchanged; a design that took such a write would tick faster and return a larger count. Commas on a reserved lane code, or arriving after the freeze, must not stop or alter the measurement. A narrow counter instance is driven past its maximum, where a wrapping design would return a small number.

// File: rtl/lsw_pkg.sv
// Shared constants for the latency stopwatch.
// Assumes a 7-bit divide field and a 2-bit lane code.
package lsw_pkg;
    localparam int DIV_W    = 7;
    localparam int LANE_W   = 2;
    localparam int MIN_DIV  = 6;
    localparam int DEF_DIV  = 6;
    localparam logic [LANE_W-1:0] MON_LANE = 2'b00;
endpackage

// File: rtl/lsw_cfg_reg.sv
// Configuration register: divide ratio, lane code, enable.
// The divide ratio is written only while the enable is currently clear, and is clamped to MIN_DIV.
module lsw_cfg_reg
    import lsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DIV_W-1:0]  wr_div,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic              wr_en,
    output logic [DIV_W-1:0]  div_q,
    output logic [LANE_W-1:0] lane_q,
    output logic              en_q
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] div_clamped;

    // Clamp illegal ratios to the floor
    always_comb div_clamped = (wr_div < FLOOR) ? FLOOR : wr_div;

    // Register update with divide-ratio write lock while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_W'(DEF_DIV);
            lane_q <= '0;
            en_q   <= 1'b0;
        end else if (we) begin
            en_q   <= wr_en;
            lane_q <= wr_lane;
            if (!en_q) div_q <= div_clamped;
        end
    end
endmodule

// File: rtl/lsw_tick_gen.sv
// Prescaler: emits one tick every div cycles while run is high.
// Assumes div >= 1; restart realigns the phase so the first tick comes div cycles later.
module lsw_tick_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    // Tick on the last phase of each period
    always_comb tick = run && (phase_q == div - DIV_W'(1));

    // Phase counter, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) phase_q <= '0;
        else if (tick)                 phase_q <= '0;
        else                           phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/lsw_comma_sel.sv
// Comma selector: passes a comma only from the monitored lane, only for the
// monitoring lane code, and only while enabled. Reserved codes select nothing.
module lsw_comma_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 2,
    parameter logic [LANE_W-1:0] MON = '0
) (
    input  logic [LANES-1:0]  comma,
    input  logic [LANE_W-1:0] lane,
    input  logic              en,
    output logic              hit
);
    logic [LANES-1:0] pick;

    // Per-lane gate: lane code must match and be the monitoring code
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pick[i] = comma[i] && (lane == LANE_W'(i)) && (LANE_W'(i) == MON);
    end

    // Combine lanes and gate with enable
    always_comb hit = en && (|pick);
endmodule

// File: rtl/lsw_counter.sv
// Saturating measurement counter with clear-on-read capture.
// Start has priority; a comma while armed freezes; a read returns 0 until a comma is captured.
module lsw_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             stop,
    input  logic             rd,
    output logic [CNT_W-1:0] count_q,
    output logic             armed_q,
    output logic             seen_q,
    output logic [CNT_W-1:0] rd_q
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Capture on read: value before this edge's update
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_q <= '0;
        else if (rd) rd_q <= seen_q ? count_q : '0;
    end

    // Measurement state: arm, freeze, saturate, clear on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b0;
            seen_q  <= 1'b0;
        end else if (start) begin
            count_q <= '0;
            armed_q <= 1'b1;
            seen_q  <= 1'b0;
        end else begin
            if (armed_q && stop) begin
                armed_q <= 1'b0;
                seen_q  <= 1'b1;
            end
            if (rd)
                count_q <= '0;
            else if (armed_q && !stop && tick && count_q != CMAX)
                count_q <= count_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/latency_stopwatch.sv
// Top: comma-triggered latency stopwatch.
// Assumes start, comma and rd_en are synchronous single-cycle pulses.
module latency_stopwatch
    import lsw_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LANE_W-1:0] cfg_lane,
    input  logic              cfg_en,
    input  logic              start,
    input  logic [LANES-1:0]  comma,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  rd_data
);
    logic [DIV_W-1:0]  cfg_div_q;
    logic [LANE_W-1:0] cfg_lane_q;
    logic              cfg_en_q;
    logic              start_acc;
    logic              tick;
    logic              hit;
    logic [CNT_W-1:0]  count_q;
    logic              armed_q;
    logic              seen_q;

    // Start is honoured only while enabled
    always_comb start_acc = start && cfg_en_q;

    lsw_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .wr_div(cfg_div), .wr_lane(cfg_lane), .wr_en(cfg_en),
        .div_q(cfg_div_q), .lane_q(cfg_lane_q), .en_q(cfg_en_q)
    );

    lsw_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(cfg_en_q), .restart(start_acc),
        .div(cfg_div_q), .tick(tick)
    );

    lsw_comma_sel #(.LANES(LANES), .LANE_W(LANE_W), .MON(MON_LANE)) u_sel (
        .comma(comma), .lane(cfg_lane_q), .en(cfg_en_q), .hit(hit)
    );

    lsw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start_acc), .tick(tick), .stop(hit),
        .rd(rd_en), .count_q(count_q), .armed_q(armed_q), .seen_q(seen_q),
        .rd_q(rd_data)
    );
endmodule

// File: rtl/lsw_checker.sv
// Property checker for the latency stopwatch, bound to every instance of the top.
module lsw_checker
    import lsw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DIV_W-1:0]  div,
    input logic [LANE_W-1:0] lane,
    input logic              hit,
    input logic              tick,
    input logic              start_acc,
    input logic              armed,
    input logic [CNT_W-1:0]  count,
    input logic              rd_en,
    input logic [CNT_W-1:0]  rd_data
);
    // R6
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(MIN_DIV));

    // R7
    div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(div));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !hit && !rd_en && !start_acc && count == {CNT_W{1'b1}})
        |=> count == {CNT_W{1'b1}});

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R8
    lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (en && lane == MON_LANE));

    // R9
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!tick && !start_acc));
endmodule

bind latency_stopwatch lsw_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(cfg_en_q), .div(cfg_div_q), .lane(cfg_lane_q),
    .hit(hit), .tick(tick), .start_acc(start_acc), .armed(armed_q),
    .count(count_q), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/latency_stopwatch_tb_top.sv
// Directed bench: one task per scenario. Inputs change on the falling edge and outputs are sampled there.
module latency_stopwatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_div = '0;
    logic [1:0]  cfg_lane = '0;
    logic        cfg_en = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  comma = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [7:0]  sat_data;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    latency_stopwatch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_lane(cfg_lane), .cfg_en(cfg_en), .start(start), .comma(comma),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    latency_stopwatch #(.CNT_W(8)) sat_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_lane(cfg_lane), .cfg_en(cfg_en), .start(start), .comma(comma),
        .rd_en(rd_en), .rd_data(sat_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int d, input int l, input bit e);
        cfg_div = 7'(d); cfg_lane = 2'(l); cfg_en = e; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_comma(input int ln);
        comma[ln] = 1'b1; @(negedge clk); comma = '0;
    endtask

    task automatic do_read();
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    endtask

    // start at E0, lane-0 comma at E0+m
    task automatic measure(input int m);
        pulse_start();
        wait_n(m - 1);
        pulse_comma(0);
    endtask

    task automatic t_reset();
        check("R1 rd_data after reset", rd_data, 0);
        do_read();
        check("R1 read after reset", rd_data, 0);
    endtask

    task automatic t_basic();
        write_cfg(6, 0, 1);
        measure(100);
        wait_n(30);
        pulse_comma(0);                       // R10 late comma ignored
        wait_n(10);
        do_read();
        check("R2 div6 m100", rd_data, 99 / 6);
        check("R10 late comma ignored", rd_data, 16);
        do_read();
        check("R3 second read clears", rd_data, 0);
    endtask

    task automatic t_div10();
        write_cfg(6, 0, 0);
        write_cfg(10, 0, 1);
        measure(53);
        do_read();
        check("R2 div10 m53", rd_data, 52 / 10);
    endtask

    task automatic t_lock();
        write_cfg(6, 0, 1);                   // en already set: ratio stays 10
        measure(53);
        do_read();
        check("R7 ratio write locked", rd_data, 5);
    endtask

    task automatic t_clamp();
        write_cfg(10, 0, 0);
        write_cfg(3, 0, 1);
        measure(100);
        do_read();
        check("R6 ratio clamped to 6", rd_data, 16);
    endtask

    task automatic t_disable();
        measure(100);
        write_cfg(6, 0, 0);
        pulse_start();
        wait_n(20);
        do_read();
        check("R9 start ignored while disabled", rd_data, 16);
    endtask

    task automatic t_lane();
        write_cfg(6, 1, 1);
        pulse_start();
        wait_n(40);
        pulse_comma(0);
        pulse_comma(1);
        wait_n(5);
        do_read();
        check("R8 reserved lane code ignores comma", rd_data, 0);
        write_cfg(6, 0, 0);
    endtask

    task automatic t_midread();
        int expv = 0;
        write_cfg(6, 0, 1);
        pulse_start();
        wait_n(19);
        do_read();                            // edge E0+20
        check("R4 read before comma", rd_data, 0);
        wait_n(29);
        pulse_comma(0);                       // edge E0+50
        do_read();
        for (int k = 1; k < 20; k++) if (6 * k > 20 && 6 * k < 50) expv++;
        check("R11 counting resumes after read", rd_data, expv);
    endtask

    task automatic t_sat();
        measure(1800);
        do_read();
        check("R5 wide counter", rd_data, 1799 / 6);
        check("R5 narrow counter saturates", sat_data, 255);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_basic();
        t_div10();
        t_lock();
        t_clamp();
        t_disable();
        t_lane();
        t_midread();
        t_sat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule